// File: doc/BRIEF.md
# Dual Mode-Selectable Timer/Counter Pair

This block holds two general-purpose timer/counters, numbered 0 and 1, each with a low count byte, a high count byte, a run bit, a gate bit, an event-source select and an overflow flag. A two-bit mode per timer sets the counter layout: a 13-bit counter (high byte over the five least significant bits of the low byte), a full 16-bit counter, an 8-bit counter that reloads from the high byte, or a split/hold mode. In split mode timer 0 becomes two independent 8-bit counters, and its high byte borrows timer 1's run bit and overflow flag. Timer 1 in split mode simply stops.

Each timer counts either machine-cycle ticks (an input strobe at one twelfth of the core clock) or falling edges on its external count pin. Software reaches every count byte and the mode and control registers through a small write/read port. The flags drive interrupt request outputs, and every timer 1 overflow is also given as a one-cycle pulse for a baud-rate consumer, even while its flag is lent to timer 0.

Top module: `dual_timer`

## Requirements
- R1: After synchronous reset all four count bytes, the mode register, the control register, `rd_data`, `ovf_flag`, `irq` and `t1_ovf_pulse` are zero.
- R2: Mode 00 counts 13 bits: the high byte over bits 4:0 of the low byte; a carry out of bit 4 increments the high byte; bits 7:5 of the low byte are never changed by counting and do not affect the count or the overflow.
- R3: When the active counter wraps from all ones to zero, the timer's flag (control bit 2 for timer 0, bit 3 for timer 1) is set, and `ovf_flag` and `irq` show it from the cycle after the wrap.
- R4: A timer advances only when its run bit (control bit 0 or 1) is 1 and either its gate bit (mode nibble bit 3) is 0 or its synchronized gate pin is 1.
- R5: With select (mode nibble bit 2) at 0 a timer counts cycles where `mc_tick` is high; with select 1 it counts synchronized falling edges of its count pin and ignores `mc_tick`.
- R6: Setting the run bit does not clear the count; counting resumes from the held value.
- R7: Mode 01 counts all 16 bits of high and low byte.
- R8: Mode 10 counts the low byte only; when it wraps the flag is set and the low byte is loaded from the high byte, which is left unchanged.
- R9: Timer 1 in mode 11 holds both count bytes as if its run bit were 0.
- R10: Timer 0 in mode 11: the low byte is an 8-bit counter under timer 0's select, gate, run bit and flag; the high byte counts `mc_tick` whenever timer 1's run bit is 1, and its wrap sets timer 1's flag.
- R11: While timer 0 is in mode 11, timer 1 in modes 00 to 10 still counts and pulses `t1_ovf_pulse` on each wrap, but does not set timer 1's flag.
- R12: A flag is cleared by writing 0 to its control bit or by a high `irq_ack` bit; a set from an overflow in the same cycle wins.
- R13: Register map: address 0 low byte 0, 1 high byte 0, 2 low byte 1, 3 high byte 1, 4 mode (timer 1 upper nibble, timer 0 lower nibble; nibble bits 1:0 mode, 2 select, 3 gate), 5 control; `rd_data` shows the register addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_tick | input | 1 | Machine-cycle strobe, one core clock wide |
| cnt_pin | input | 2 | External count pins, bit n for timer n |
| gate_pin | input | 2 | External gate pins, bit n for timer n |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for write and read |
| wr_data | input | BYTE_W | Write data |
| irq_ack | input | 2 | Interrupt acknowledge, clears flag n |
| rd_data | output | BYTE_W | Registered read data |
| ovf_flag | output | 2 | Overflow flags |
| irq | output | 2 | Interrupt requests |
| t1_ovf_pulse | output | 1 | One-cycle pulse on every timer 1 wrap |

## Verification
The hold and stability properties assume that no register write lands in the cycle being judged, so each one is conditioned on `wr_en` low; the stimulus writes configuration only between counting steps. The flag properties assume an acknowledge can coincide with an overflow, and the stimulus creates that collision on purpose. Count pins idle high and gate pins are changed well before ticks are applied, so the two-stage synchronizer latency never straddles a check.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_13  = 2'b00,
    MODE_16  = 2'b01,
    MODE_RLD = 2'b10,
    MODE_SPL = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      sel;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam int A_TL0  = 0;
  localparam int A_TH0  = 1;
  localparam int A_TL1  = 2;
  localparam int A_TH1  = 3;
  localparam int A_MODE = 4;
  localparam int A_CTRL = 5;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_LVL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk) begin
      if (rst) sr <= {STAGES{RST_LVL[i]}};
      else     sr <= {sr[STAGES-2:0], din[i]};
    end
    assign dout[i] = sr[STAGES-1];
  end
endmodule

// File: rtl/tmr_step.sv
module tmr_step
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int M0_LOW = 5
) (
  input  tmr_mode_e         mode,
  input  logic              inc,
  input  logic [BYTE_W-1:0] tl,
  input  logic [BYTE_W-1:0] th,
  output logic [BYTE_W-1:0] tl_nx,
  output logic [BYTE_W-1:0] th_nx,
  output logic              ovf
);
  logic [M0_LOW:0]     low_sum;
  logic [BYTE_W:0]     hi_sum;
  logic [BYTE_W:0]     lo_sum;
  logic [2*BYTE_W:0]   wide_sum;

  assign low_sum  = {1'b0, tl[M0_LOW-1:0]} + 1'b1;
  assign hi_sum   = {1'b0, th} + 1'b1;
  assign lo_sum   = {1'b0, tl} + 1'b1;
  assign wide_sum = {1'b0, th, tl} + 1'b1;

  always_comb begin
    tl_nx = tl;
    th_nx = th;
    ovf   = 1'b0;
    if (inc) begin
      case (mode)
        MODE_13: begin
          tl_nx = {tl[BYTE_W-1:M0_LOW], low_sum[M0_LOW-1:0]};
          if (low_sum[M0_LOW]) begin
            th_nx = hi_sum[BYTE_W-1:0];
            ovf   = hi_sum[BYTE_W];
          end
        end
        MODE_16: {ovf, th_nx, tl_nx} = wide_sum;
        MODE_RLD: begin
          if (lo_sum[BYTE_W]) begin
            tl_nx = th;
            ovf   = 1'b1;
          end else begin
            tl_nx = lo_sum[BYTE_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import tmr_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int M0_LOW      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mc_tick,
  input  logic [1:0]        cnt_pin,
  input  logic [1:0]        gate_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        irq_ack,
  output logic [BYTE_W-1:0] rd_data,
  output logic [1:0]        ovf_flag,
  output logic [1:0]        irq,
  output logic              t1_ovf_pulse
);
  localparam int CTRL_PAD = BYTE_W - 4;

  logic [BYTE_W-1:0] tl0, th0, tl1, th1;
  logic [7:0]        mode_q;
  logic              run0, run1;
  tmr_cfg_t          cfg0, cfg1;

  assign cfg0 = tmr_cfg_t'(mode_q[3:0]);
  assign cfg1 = tmr_cfg_t'(mode_q[7:4]);

  // pin synchronizers: gate pins reset low, count pins idle high
  logic [3:0] pin_lvl;
  tmr_pin_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_LVL(4'b0011)) u_sync (
    .clk(clk), .rst(rst), .din({gate_pin, cnt_pin}), .dout(pin_lvl)
  );

  logic [1:0] cnt_prev, cnt_fall;
  always_ff @(posedge clk) begin
    if (rst) cnt_prev <= 2'b11;
    else     cnt_prev <= pin_lvl[1:0];
  end
  assign cnt_fall = cnt_prev & ~pin_lvl[1:0];

  // event and enable per timer
  logic inc0, inc1, th0_inc;
  assign inc0    = run0 & (~cfg0.gate | pin_lvl[2]) & (cfg0.sel ? cnt_fall[0] : mc_tick);
  assign inc1    = run1 & (~cfg1.gate | pin_lvl[3]) & (cfg1.sel ? cnt_fall[1] : mc_tick);
  assign th0_inc = run1 & mc_tick;

  logic [BYTE_W-1:0] s0_tl, s0_th, s1_tl, s1_th;
  logic              s0_ovf, s1_ovf;

  tmr_step #(.BYTE_W(BYTE_W), .M0_LOW(M0_LOW)) u_step0 (
    .mode(cfg0.mode), .inc(inc0), .tl(tl0), .th(th0),
    .tl_nx(s0_tl), .th_nx(s0_th), .ovf(s0_ovf)
  );
  tmr_step #(.BYTE_W(BYTE_W), .M0_LOW(M0_LOW)) u_step1 (
    .mode(cfg1.mode), .inc(inc1), .tl(tl1), .th(th1),
    .tl_nx(s1_tl), .th_nx(s1_th), .ovf(s1_ovf)
  );

  // split mode of timer 0: two free 8-bit counters
  logic              split0;
  logic [BYTE_W:0]   spl_lo, spl_hi;
  logic [BYTE_W-1:0] tl0_nx, th0_nx;
  logic              flag0_set, flag1_set;

  assign split0 = (cfg0.mode == MODE_SPL);
  assign spl_lo = {1'b0, tl0} + 1'b1;
  assign spl_hi = {1'b0, th0} + 1'b1;

  always_comb begin
    if (split0) begin
      tl0_nx    = inc0    ? spl_lo[BYTE_W-1:0] : tl0;
      th0_nx    = th0_inc ? spl_hi[BYTE_W-1:0] : th0;
      flag0_set = inc0 & spl_lo[BYTE_W];
      flag1_set = th0_inc & spl_hi[BYTE_W];
    end else begin
      tl0_nx    = s0_tl;
      th0_nx    = s0_th;
      flag0_set = s0_ovf;
      flag1_set = s1_ovf;
    end
  end

  logic wr_ctrl;
  assign wr_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));

  always_ff @(posedge clk) begin
    if (rst) begin
      tl0 <= '0; th0 <= '0; tl1 <= '0; th1 <= '0;
      mode_q <= '0; run0 <= 1'b0; run1 <= 1'b0;
      ovf_flag <= '0; t1_ovf_pulse <= 1'b0; rd_data <= '0;
    end else begin
      tl0 <= tl0_nx; th0 <= th0_nx;
      tl1 <= s1_tl;  th1 <= s1_th;
      t1_ovf_pulse <= s1_ovf;
      if (wr_en) begin
        case (addr)
          ADDR_W'(A_TL0):  tl0 <= wr_data;
          ADDR_W'(A_TH0):  th0 <= wr_data;
          ADDR_W'(A_TL1):  tl1 <= wr_data;
          ADDR_W'(A_TH1):  th1 <= wr_data;
          ADDR_W'(A_MODE): mode_q <= wr_data[7:0];
          ADDR_W'(A_CTRL): begin run0 <= wr_data[0]; run1 <= wr_data[1]; end
          default: ;
        endcase
      end
      // flags: overflow set beats software write and acknowledge
      if (flag0_set)       ovf_flag[0] <= 1'b1;
      else if (wr_ctrl)    ovf_flag[0] <= wr_data[2];
      else if (irq_ack[0]) ovf_flag[0] <= 1'b0;
      if (flag1_set)       ovf_flag[1] <= 1'b1;
      else if (wr_ctrl)    ovf_flag[1] <= wr_data[3];
      else if (irq_ack[1]) ovf_flag[1] <= 1'b0;
      case (addr)
        ADDR_W'(A_TL0):  rd_data <= tl0;
        ADDR_W'(A_TH0):  rd_data <= th0;
        ADDR_W'(A_TL1):  rd_data <= tl1;
        ADDR_W'(A_TH1):  rd_data <= th1;
        ADDR_W'(A_MODE): rd_data <= BYTE_W'(mode_q);
        ADDR_W'(A_CTRL): rd_data <= {{CTRL_PAD{1'b0}}, ovf_flag[1], ovf_flag[0], run1, run0};
        default:         rd_data <= '0;
      endcase
    end
  end

  assign irq = ovf_flag;
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        irq_ack,
  input logic [7:0]        mode_q,
  input logic              run0,
  input logic              flag0_set,
  input logic              flag1_set,
  input logic [1:0]        ovf_flag,
  input logic [BYTE_W-1:0] tl0,
  input logic [BYTE_W-1:0] th0,
  input logic [BYTE_W-1:0] tl1,
  input logic [BYTE_W-1:0] th1
);
  assert_set_wins0_R12: assert property (@(posedge clk) disable iff (rst)
    flag0_set |=> ovf_flag[0]);
  assert_set_flag1_R3: assert property (@(posedge clk) disable iff (rst)
    flag1_set |=> ovf_flag[1]);
  assert_ack_clears0_R12: assert property (@(posedge clk) disable iff (rst)
    irq_ack[0] && !flag0_set && !wr_en |=> !ovf_flag[0]);
  assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (rst)
    mode_q[1:0] != 2'b11 && !run0 && !wr_en |=> $stable(tl0) && $stable(th0));
  assert_t1_hold_R9: assert property (@(posedge clk) disable iff (rst)
    mode_q[5:4] == 2'b11 && !wr_en |=> $stable(tl1) && $stable(th1));
  assert_reload_keeps_high_R8: assert property (@(posedge clk) disable iff (rst)
    mode_q[1:0] == 2'b10 && !wr_en |=> $stable(th0));
endmodule

bind dual_timer dual_timer_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .irq_ack(irq_ack), .mode_q(mode_q),
  .run0(run0), .flag0_set(flag0_set), .flag1_set(flag1_set), .ovf_flag(ovf_flag),
  .tl0(tl0), .th0(th0), .tl1(tl1), .th1(th1)
);

// File: tb/dual_timer_tb.sv
module dual_timer_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mc_tick = 1'b0;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] irq_ack = '0;
  logic [7:0] rd_data;
  logic [1:0] ovf_flag, irq;
  logic       t1_ovf_pulse;

  int checks = 0;
  int errors = 0;
  int baud_cnt = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) if (t1_ovf_pulse) baud_cnt <= baud_cnt + 1;

  dual_timer u_dut (
    .clk(clk), .rst(rst), .mc_tick(mc_tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .irq_ack(irq_ack),
    .rd_data(rd_data), .ovf_flag(ovf_flag), .irq(irq), .t1_ovf_pulse(t1_ovf_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    cnt_pin = 2'b11; gate_pin = 2'b00; mc_tick = 0; irq_ack = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; addr = 3'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); addr = 3'(a);
    @(negedge clk); d = int'(rd_data);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); mc_tick = 1'b1;
      @(negedge clk); mc_tick = 1'b0;
    end
  endtask

  task automatic expect_reg(input string req, input int a, input int exp);
    int d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    do_reset();
    for (int a = 0; a < 6; a++) expect_reg("R1 register", a, 0);
    check("R1 flags", int'(ovf_flag), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 pulse", int'(t1_ovf_pulse), 0);
    wr(4, 8'hA5); expect_reg("R13 mode readback", 4, 8'hA5);
    wr(3, 8'h3C); expect_reg("R13 high byte 1 readback", 3, 8'h3C);
  endtask

  task automatic t_mode16();
    do_reset();
    wr(0, 8'hFE); wr(1, 8'hFF); wr(4, 8'h01); wr(5, 8'h01);
    tick(1);
    expect_reg("R7 low", 0, 8'hFF);
    check("R7 no flag yet", int'(ovf_flag[0]), 0);
    tick(1);
    expect_reg("R7 low wrap", 0, 0);
    expect_reg("R7 high wrap", 1, 0);
    check("R3 flag0", int'(ovf_flag[0]), 1);
    check("R3 irq0", int'(irq[0]), 1);
    expect_reg("R3 control shows flag0", 5, 8'h05);
    wr(5, 8'h01);
    check("R12 write clears flag0", int'(ovf_flag[0]), 0);
  endtask

  task automatic t_mode13();
    do_reset();
    wr(0, 8'hFF); wr(1, 8'hFF); wr(4, 8'h00); wr(5, 8'h01);
    tick(1);
    expect_reg("R2 low wrap keeps top bits", 0, 8'hE0);
    expect_reg("R2 high wrap", 1, 0);
    check("R2 flag on 13-bit wrap", int'(ovf_flag[0]), 1);
    wr(5, 8'h01); wr(0, 8'h1F); wr(1, 8'h05);
    tick(1);
    expect_reg("R2 carry low", 0, 0);
    expect_reg("R2 carry high", 1, 8'h06);
    check("R2 no flag on carry", int'(ovf_flag[0]), 0);
  endtask

  task automatic t_reload();
    do_reset();
    wr(1, 8'h80); wr(0, 8'hFE); wr(4, 8'h02); wr(5, 8'h01);
    tick(2);
    expect_reg("R8 reloaded low", 0, 8'h80);
    expect_reg("R8 high unchanged", 1, 8'h80);
    check("R8 flag", int'(ovf_flag[0]), 1);
    tick(1);
    expect_reg("R8 counts on", 0, 8'h81);
  endtask

  task automatic t_gate();
    do_reset();
    wr(4, 8'h09); wr(5, 8'h01);
    tick(3);
    expect_reg("R4 gated off", 0, 0);
    @(negedge clk); gate_pin[0] = 1'b1;
    repeat (4) @(negedge clk);
    tick(2);
    expect_reg("R4 gated on", 0, 2);
  endtask

  task automatic t_resume();
    do_reset();
    wr(4, 8'h01); wr(5, 8'h01);
    tick(3);
    wr(5, 8'h00);
    tick(2);
    expect_reg("R6 held while stopped", 0, 3);
    wr(5, 8'h01);
    tick(1);
    expect_reg("R6 resumes from held", 0, 4);
  endtask

  task automatic t_select();
    do_reset();
    wr(4, 8'h05); wr(5, 8'h01);
    tick(3);
    expect_reg("R5 ticks ignored", 0, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); cnt_pin[0] = 1'b0;
      repeat (3) @(negedge clk);
      cnt_pin[0] = 1'b1;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    expect_reg("R5 pin edges counted", 0, 3);
  endtask

  task automatic t_t1();
    int b0;
    do_reset();
    wr(4, 8'h10); wr(5, 8'h02);
    tick(2);
    expect_reg("R9 t1 counting", 2, 2);
    wr(4, 8'h30);
    tick(2);
    expect_reg("R9 t1 held in mode 3", 2, 2);
    wr(4, 8'h10); wr(2, 8'hFF); wr(3, 8'hFF);
    b0 = baud_cnt;
    tick(1);
    @(negedge clk);
    check("R3 flag1", int'(ovf_flag[1]), 1);
    check("R11 pulse in normal use", baud_cnt - b0, 1);
  endtask

  task automatic t_split();
    int b0;
    do_reset();
    wr(0, 8'hFF); wr(1, 8'h10); wr(2, 8'hFF); wr(3, 8'hFF);
    wr(4, 8'h13); wr(5, 8'h01);
    tick(1);
    expect_reg("R10 low byte wraps", 0, 0);
    check("R10 flag0 from low byte", int'(ovf_flag[0]), 1);
    expect_reg("R10 high byte needs run1", 1, 8'h10);
    b0 = baud_cnt;
    wr(5, 8'h03);
    tick(1);
    @(negedge clk);
    expect_reg("R10 low byte", 0, 1);
    expect_reg("R10 high byte counts", 1, 8'h11);
    expect_reg("R11 t1 still counts", 2, 0);
    check("R11 pulse", baud_cnt - b0, 1);
    check("R11 flag1 not set by t1", int'(ovf_flag[1]), 0);
    wr(1, 8'hFF);
    tick(1);
    expect_reg("R10 high byte wraps", 1, 0);
    check("R10 flag1 from high byte", int'(ovf_flag[1]), 1);
  endtask

  task automatic t_ack();
    do_reset();
    wr(0, 8'hFF); wr(1, 8'hFF); wr(4, 8'h01); wr(5, 8'h01);
    tick(1);
    check("R12 flag before ack", int'(ovf_flag[0]), 1);
    @(negedge clk); irq_ack[0] = 1'b1;
    @(negedge clk); irq_ack[0] = 1'b0;
    check("R12 ack clears", int'(ovf_flag[0]), 0);
    wr(0, 8'hFF); wr(1, 8'hFF);
    @(negedge clk); mc_tick = 1'b1; irq_ack[0] = 1'b1;
    @(negedge clk); mc_tick = 1'b0; irq_ack[0] = 1'b0;
    check("R12 set wins over ack", int'(ovf_flag[0]), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mode16();
    t_mode13();
    t_reload();
    t_gate();
    t_resume();
    t_select();
    t_t1();
    t_split();
    t_ack();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule